// File: doc/BRIEF.md
# Parallel FRAM Cycle Controller

This block sits between a host that issues one-word read or write requests and a 32768 x 8 parallel nonvolatile memory whose every access must begin with a chip-enable falling edge and end with a chip-enable-high precharge. The host presents a request with an address, a direction flag and write data. The controller frames one complete memory cycle for it: an address setup clock, an access phase with chip enable low, and a precharge phase with chip enable high. Only then does it signal that it can take the next request.

Reads and writes follow the same cycle length, so the host sees a fixed latency from acceptance to the next ready. There is never a busy poll after a write. Writes are chip-enable-controlled: write enable goes low one clock before chip enable falls and rises on the same edge that raises chip enable, and output enable stays high throughout. Reads release the data bus, assert output enable while chip enable is low, and capture the returned byte on the edge that ends the access.

Top module: `fram_cycle_ctrl`

## Requirements
- R1: While and after reset, with no request, host_ready is 1, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and host_rvalid is 0.
- R2: A request is accepted on a rising clock edge where host_req and host_ready are both 1. host_ready then stays 0 and returns to 1 exactly 1 + ACC_CLKS + PRE_CLKS clocks after the accepting edge, for reads and writes alike.
- R3: mem_addr and the direction are presented one clock before mem_ce_n falls, and mem_ce_n stays low for exactly ACC_CLKS clocks in every cycle.
- R4: In a write, mem_we_n is 0 from the clock before mem_ce_n falls until mem_ce_n rises (ACC_CLKS + 1 clocks), mem_oe_n stays 1, and mem_dq_oe is 1 with mem_dq_out equal to the accepted write data for those same clocks.
- R5: In a read, mem_oe_n is 0 exactly while mem_ce_n is 0, mem_we_n stays 1 and mem_dq_oe stays 0.
- R6: In a read, host_rdata takes mem_dq_in as sampled on the edge that raises mem_ce_n, and host_rvalid is a single-clock pulse in the first clock with mem_ce_n high again. Writes produce no host_rvalid.
- R7: Between two accesses mem_ce_n is high for at least PRE_CLKS + 2 clocks, including back-to-back accesses to the same address.
- R8: mem_addr does not change while mem_ce_n is low, even when host_addr changes after acceptance.
- R9: A request raised and dropped while host_ready is 0 is ignored. It starts no cycle and does not alter memory contents.
- R10: A read or write may be accepted in the first clock host_ready is 1 after a write, with no extra wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Word address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Controller can accept a request |
| host_rdata | output | 8 | Last read data |
| host_rvalid | output | 1 | One-clock pulse when host_rdata is new |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 8 | Data driven to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned by memory |

## Verification
Single writes and reads are run at the lowest address, the highest address and a middle address, with data 00, FF, A5 and 3C. Distinct bytes per address show that each write reaches its own location and that each read returns the byte at that location rather than stale data. A write followed at once by a read of the same address, and a read followed by a read, separate proper precharge spacing from a controller that would merge accesses to the same address. A request pulsed during a busy cycle with conflicting data shows whether such a request is truly dropped. The read-back confirms that the memory still holds the original byte.

// File: rtl/fram_cycle_ctrl.sv
module fram_cycle_ctrl #(
  parameter int AW       = 15,
  parameter int DW       = 8,
  parameter int ACC_CLKS = 4,
  parameter int PRE_CLKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int CNT_MAX = (ACC_CLKS > PRE_CLKS) ? ACC_CLKS : PRE_CLKS;
  localparam int CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACC, S_PRE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          is_wr;

  assign host_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      is_wr       <= 1'b0;
      mem_ce_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_dq_oe   <= 1'b0;
      mem_addr    <= '0;
      mem_dq_out  <= '0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (host_req) begin
            st         <= S_SETUP;
            mem_addr   <= host_addr;
            is_wr      <= host_wr;
            mem_we_n   <= ~host_wr;
            mem_dq_oe  <= host_wr;
            mem_dq_out <= host_wdata;
          end
        end
        S_SETUP: begin
          st       <= S_ACC;
          mem_ce_n <= 1'b0;
          mem_oe_n <= is_wr;
          cnt      <= CW'(ACC_CLKS - 1);
        end
        S_ACC: begin
          if (cnt == '0) begin
            st        <= S_PRE;
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            cnt       <= CW'(PRE_CLKS - 1);
            if (!is_wr) begin
              host_rdata  <= mem_dq_in;
              host_rvalid <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) st <= S_IDLE;
          else           cnt <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

module fram_cycle_ctrl_chk #(
  parameter int AW       = 15,
  parameter int ACC_CLKS = 4,
  parameter int PRE_CLKS = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_ready,
  input logic          host_rvalid,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr
);
  int unsigned hi_run;
  int unsigned lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= 32'hFFFF_FFFF;
      lo_run <= 0;
    end else begin
      if (mem_ce_n) begin
        lo_run <= 0;
        if (hi_run != 32'hFFFF_FFFF) hi_run <= hi_run + 1;
      end else begin
        hi_run <= 0;
        lo_run <= lo_run + 1;
      end
    end
  end

  p_busy_while_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !host_ready);
  p_access_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> lo_run == ACC_CLKS);
  p_we_leads_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ce_n) && !mem_we_n) |-> $past(!mem_we_n));
  p_we_falls_high_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> mem_ce_n);
  p_oe_off_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  p_bus_drive_only_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_we_n));
  p_rvalid_at_ce_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> ($rose(mem_ce_n) && $past(mem_we_n)));
  p_precharge_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> hi_run >= PRE_CLKS + 2);
  p_addr_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind fram_cycle_ctrl fram_cycle_ctrl_chk #(
  .AW(AW), .ACC_CLKS(ACC_CLKS), .PRE_CLKS(PRE_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .host_rvalid(host_rvalid),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr)
);

// File: tb/tb_fram_cycle_ctrl.sv
module tb_fram_cycle_ctrl;
  localparam int ACC = 4;
  localparam int PRE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [14:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ready, host_rvalid;
  logic [7:0]  host_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] fmem [int];

  always #5 clk = ~clk;

  fram_cycle_ctrl #(.ACC_CLKS(ACC), .PRE_CLKS(PRE)) dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) fmem[int'(mem_addr)] = mem_dq_out;
    if (!mem_ce_n && !mem_oe_n)
      mem_dq_in = fmem.exists(int'(mem_addr)) ? fmem[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 8'h00;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_access(input bit wr, input logic [14:0] a, input logic [7:0] d,
                           input logic [7:0] exp_rd, input bit inject,
                           output int lead, output int tail);
    int idx = 0, first_low = -1, lows = 0, addr_bad = 0, we_lows = 0;
    int oe_lows = 0, oe_in_ce = 0, dq_cnt = 0, dq_bad = 0, rv_idx = -1, rv_data = 0;
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    lead = 1; tail = 0;
    @(negedge clk);
    host_req = 1'b0; host_addr = ~a; host_wdata = ~d;
    while (!host_ready && idx < 40) begin
      if (!mem_ce_n) begin
        if (first_low < 0) first_low = idx;
        lows++;
        if (mem_addr != a) addr_bad++;
        if (!mem_oe_n) oe_in_ce++;
      end else if (first_low < 0) lead++;
      else tail++;
      if (!mem_we_n) we_lows++;
      if (!mem_oe_n) oe_lows++;
      if (mem_dq_oe) begin
        dq_cnt++;
        if (mem_dq_out != d) dq_bad++;
      end
      if (host_rvalid) begin rv_idx = idx; rv_data = int'(host_rdata); end
      if (inject && idx == 2) begin
        host_req = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = 8'h99;
      end
      if (inject && idx == 3) host_req = 1'b0;
      @(negedge clk);
      idx++;
    end
    chk(idx == 1 + ACC + PRE, "R2 ready latency", idx, 1 + ACC + PRE);
    chk(first_low == 1, "R3 ce falls after setup clock", first_low, 1);
    chk(lows == ACC, "R3 ce low length", lows, ACC);
    chk(addr_bad == 0, "R8 address steady", addr_bad, 0);
    if (wr) begin
      chk(we_lows == ACC + 1, "R4 we low span", we_lows, ACC + 1);
      chk(oe_lows == 0, "R4 oe high in write", oe_lows, 0);
      chk(dq_cnt == ACC + 1 && dq_bad == 0, "R4 data driven", dq_cnt, ACC + 1);
      chk(rv_idx == -1, "R6 no rvalid on write", rv_idx, -1);
    end else begin
      chk(we_lows == 0, "R5 we high in read", we_lows, 0);
      chk(oe_lows == ACC && oe_in_ce == ACC, "R5 oe with ce", oe_lows, ACC);
      chk(dq_cnt == 0, "R5 bus released", dq_cnt, 0);
      chk(rv_idx == ACC + 1, "R6 rvalid timing", rv_idx, ACC + 1);
      chk(rv_data == int'(exp_rd), "R6 read data", rv_data, int'(exp_rd));
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(host_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !host_rvalid,
        "R1 outputs in reset", int'(mem_ce_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !host_rvalid,
        "R1 outputs after reset", int'(host_ready), 1);
  endtask

  task automatic t_single();
    int l, t;
    do_access(1'b1, 15'h1234, 8'hA5, 8'h00, 1'b0, l, t);
    do_access(1'b0, 15'h1234, 8'h00, 8'hA5, 1'b0, l, t);
  endtask

  task automatic t_back_to_back();
    int l1, t1, l2, t2, l3, t3;
    do_access(1'b1, 15'h7FFF, 8'h3C, 8'h00, 1'b0, l1, t1);
    do_access(1'b0, 15'h7FFF, 8'h00, 8'h3C, 1'b0, l2, t2);
    chk(t1 + l2 == PRE + 2, "R10 R7 read right after write", t1 + l2, PRE + 2);
    do_access(1'b0, 15'h7FFF, 8'h00, 8'h3C, 1'b0, l3, t3);
    chk(t2 + l3 == PRE + 2, "R7 same address gap", t2 + l3, PRE + 2);
  endtask

  task automatic t_edges();
    int l, t;
    do_access(1'b1, 15'h0000, 8'hFF, 8'h00, 1'b0, l, t);
    do_access(1'b1, 15'h0001, 8'h00, 8'h00, 1'b0, l, t);
    do_access(1'b0, 15'h0000, 8'h00, 8'hFF, 1'b0, l, t);
    do_access(1'b0, 15'h0001, 8'h00, 8'h00, 1'b0, l, t);
    do_access(1'b0, 15'h7FFF, 8'h00, 8'h3C, 1'b0, l, t);
  endtask

  task automatic t_busy_req();
    int l, t, falls = 0;
    do_access(1'b1, 15'h0100, 8'h11, 8'h00, 1'b1, l, t);
    repeat (5) begin
      if (!mem_ce_n) falls++;
      @(negedge clk);
    end
    chk(falls == 0 && host_ready, "R9 busy request starts no cycle", falls, 0);
    do_access(1'b0, 15'h0100, 8'h00, 8'h11, 1'b0, l, t);
  endtask

  initial begin
    t_reset();
    t_single();
    t_back_to_back();
    t_edges();
    t_busy_req();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule